// File: doc/BRIEF.md
# Wide Send Byte Packer with Chained Odd-Byte Hold

This block sits on the send side of a 16-bit data path. It takes a byte stream from memory and emits 16-bit words with per-lane byte enables. Each transfer is started by a move command that carries a byte count and three flags: chained or normal, receive or send, and narrow or wide. Bytes are packed two per word, with the earlier byte in the low lane.

When a chained wide send ends with one byte left over, that byte is not put on the output. It is kept in a holding register and a status flag is raised. The next wide send joins the kept byte with its own first byte into one word, whether that next move is chained or normal. After the joined word has been taken, the flag drops by itself. Starting a receive, running any narrow transfer, or a software clear pulse also drops the flag, and the kept byte is then thrown away. A command with a zero count changes nothing.

Software can watch the flag to find a stranded byte after an aborted transfer and clear it before restarting. The reset input is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `wide_byte_packer`

## Requirements
- R1: In a wide send, bytes are packed two per word: the earlier byte goes in `out_data[7:0]`, the later one in `out_data[15:8]`, and `out_be` is 2'b11 (bit 0 marks the low lane, bit 1 the high lane).
- R2: A normal wide send that ends with one unpaired byte emits a final word {8'h00, byte} with `out_be` = 2'b01. `out_be` is never 2'b00 or 2'b10 while `out_valid` is high.
- R3: A chained wide send that ends with one unpaired byte does not emit that byte. `hold_flag` rises on the clock edge that accepts that byte.
- R4: A normal move never sets `hold_flag`.
- R5: When `hold_flag` is set at the start of a wide send (chained or normal), the first word is {first new byte, kept byte} with `out_be` = 2'b11. The remaining bytes are then packed as in R1 to R3.
- R6: `hold_flag` clears on the clock edge at which the joined word is taken (`out_valid` and `out_ready` both high), unless that same edge sets a new hold.
- R7: Accepting a receive command (`cmd_recv`=1) or a narrow command (`cmd_narrow`=1) with a nonzero count clears `hold_flag` and discards the kept byte. A narrow send emits each byte alone as {8'h00, byte} with `out_be` = 2'b01, and a receive command consumes no bytes.
- R8: A `sw_clear` pulse clears `hold_flag` on the next edge and discards a kept byte that has not yet been joined. If it coincides with the edge that would set the hold, the clear wins and the byte is dropped.
- R9: A command with a zero count is accepted and leaves `hold_flag`, the kept byte and the outputs unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_be` hold their values.
- R11: After reset, `out_valid` is 0, `hold_flag` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Move command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_count | input | CNT_W | Number of bytes in the move |
| cmd_chained | input | 1 | 1 = chained move, 0 = normal move |
| cmd_recv | input | 1 | 1 = receive direction |
| cmd_narrow | input | 1 | 1 = narrow (8-bit) transfer |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | 16 | Output word |
| out_be | output | 2 | Lane enables: bit 0 low byte, bit 1 high byte |
| hold_flag | output | 1 | A kept byte awaits joining |
| sw_clear | input | 1 | Software clear of the flag and kept byte |

## Verification
On every cycle the assertions check that the flag rises only on the final byte of a chained wide move, that a receive or narrow command, a software clear or a delivered joined word leaves the flag low, that the output is stable under backpressure, that only legal lane enables appear, and that a zero-count command starts no transfer. Only the bench's scenarios can show the joined word's content and position in the stream. They also show that a discarded byte never appears later, that the kept byte survives a zero-count command, and that a clear coinciding with the final byte wins. Each of these needs a multi-command history whose expected words are compared in order.

// File: rtl/wbp_pkg.sv
`timescale 1ns/1ps
package wbp_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  localparam logic [LANES-1:0] BE_LOW  = 2'b01;
  localparam logic [LANES-1:0] BE_FULL = 2'b11;

  typedef struct packed {
    logic [LANES-1:0]  be;
    logic [WORD_W-1:0] data;
    logic              joined;
  } word_t;
endpackage

// File: rtl/wbp_cmd_seq.sv
`timescale 1ns/1ps
module wbp_cmd_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_chained,
  input  logic             cmd_recv,
  input  logic             cmd_narrow,
  input  logic             in_fire,
  output logic             cmd_ready,
  output logic             busy,
  output logic             chn,
  output logic             nar,
  output logic             first,
  output logic             last,
  output logic             cmd_clr
);
  logic             busy_q, busy_n;
  logic             chn_q, chn_n;
  logic             nar_q, nar_n;
  logic             first_q, first_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             cmd_fire, nonzero, take, ce;

  always_comb begin
    cmd_fire = cmd_valid & ~busy_q;
    nonzero  = |cmd_count;
    take     = cmd_fire & nonzero & ~cmd_recv;
    cmd_clr  = cmd_fire & nonzero & (cmd_recv | cmd_narrow);
    ce       = take | in_fire;

    busy_n  = busy_q;
    chn_n   = chn_q;
    nar_n   = nar_q;
    first_n = first_q;
    rem_n   = rem_q;
    if (take) begin
      busy_n  = 1'b1;
      chn_n   = cmd_chained;
      nar_n   = cmd_narrow;
      first_n = 1'b1;
      rem_n   = cmd_count;
    end else if (in_fire) begin
      rem_n   = rem_q - CNT_W'(1);
      first_n = 1'b0;
      if (rem_q == CNT_W'(1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      chn_q   <= 1'b0;
      nar_q   <= 1'b0;
      first_q <= 1'b0;
      rem_q   <= '0;
    end else if (ce) begin
      busy_q  <= busy_n;
      chn_q   <= chn_n;
      nar_q   <= nar_n;
      first_q <= first_n;
      rem_q   <= rem_n;
    end
  end

  assign cmd_ready = ~busy_q;
  assign busy      = busy_q;
  assign chn       = chn_q;
  assign nar       = nar_q;
  assign first     = first_q;
  assign last      = (rem_q == CNT_W'(1));

  // R9
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_count == '0) |=> !busy);

  // R1
  busy_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_q != '0);
endmodule

// File: rtl/wbp_joiner.sv
`timescale 1ns/1ps
module wbp_joiner
  import wbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              busy,
  input  logic              chn,
  input  logic              nar,
  input  logic              first,
  input  logic              last,
  input  logic              cmd_clr,
  input  logic              sw_clear,
  input  logic              join_sent,
  output logic              emit,
  output word_t             emit_word,
  output logic              flag
);
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic              lov_q, lov_n;
  logic              flag_q, flag_n;
  logic              drop_kept, lo_eff, set_hold, ce;

  always_comb begin
    drop_kept = sw_clear & lov_q & (~busy | first);
    lo_eff    = lov_q & ~drop_kept;
    lo_n      = lo_q;
    lov_n     = lo_eff & ~cmd_clr;
    set_hold  = 1'b0;
    emit      = 1'b0;
    emit_word = '0;

    if (in_fire) begin
      if (nar) begin
        emit           = 1'b1;
        emit_word.be   = BE_LOW;
        emit_word.data = {{BYTE_W{1'b0}}, in_data};
      end else if (lo_eff) begin
        emit             = 1'b1;
        emit_word.be     = BE_FULL;
        emit_word.data   = {in_data, lo_q};
        emit_word.joined = first;
        lov_n            = 1'b0;
      end else if (last) begin
        if (chn) begin
          if (!sw_clear) begin
            lo_n     = in_data;
            lov_n    = 1'b1;
            set_hold = 1'b1;
          end
        end else begin
          emit           = 1'b1;
          emit_word.be   = BE_LOW;
          emit_word.data = {{BYTE_W{1'b0}}, in_data};
        end
      end else begin
        lo_n  = in_data;
        lov_n = 1'b1;
      end
    end

    if (sw_clear || cmd_clr) flag_n = 1'b0;
    else if (set_hold)       flag_n = 1'b1;
    else if (join_sent)      flag_n = 1'b0;
    else                     flag_n = flag_q;

    ce = in_fire | sw_clear | cmd_clr | join_sent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      lov_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (ce) begin
      lo_q   <= lo_n;
      lov_q  <= lov_n;
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;

  // R3
  hold_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(in_fire && chn && last && !nar));

  // R8
  sw_clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> !flag_q);

  // R7
  cmd_clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !flag_q);

  // R6
  join_sent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_sent && !(in_fire && last && chn)) |=> !flag_q);
endmodule

// File: rtl/wbp_out_stage.sv
`timescale 1ns/1ps
module wbp_out_stage
  import wbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  word_t             emit_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_be,
  output logic              slot_free,
  output logic              join_sent
);
  logic  vld_q, vld_n;
  word_t w_q, w_n;
  logic  ce;

  always_comb begin
    slot_free = ~vld_q | out_ready;
    join_sent = vld_q & out_ready & w_q.joined;
    vld_n     = vld_q;
    w_n       = w_q;
    if (emit) begin
      vld_n = 1'b1;
      w_n   = emit_word;
    end else if (out_ready) begin
      vld_n = 1'b0;
    end
    ce = emit | out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      w_q   <= '0;
    end else if (ce) begin
      vld_q <= vld_n;
      w_q   <= w_n;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = w_q.data;
  assign out_be    = w_q.be;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be)));

  // R2
  lane_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be == BE_LOW || out_be == BE_FULL));

  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> slot_free);
endmodule

// File: rtl/wide_byte_packer.sv
`timescale 1ns/1ps
module wide_byte_packer
  import wbp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_chained,
  input  logic              cmd_recv,
  input  logic              cmd_narrow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_be,
  output logic              hold_flag,
  input  logic              sw_clear
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic  arst_n;
  logic  busy, chn, nar, first, last, cmd_clr;
  logic  in_fire, emit, slot_free, join_sent;
  word_t emit_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign arst_n = rs_q[SYNC_STAGES-1];

  assign in_ready = busy & slot_free;
  assign in_fire  = in_valid & in_ready;

  wbp_cmd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(arst_n),
    .cmd_valid(cmd_valid), .cmd_count(cmd_count), .cmd_chained(cmd_chained),
    .cmd_recv(cmd_recv), .cmd_narrow(cmd_narrow), .in_fire(in_fire),
    .cmd_ready(cmd_ready), .busy(busy), .chn(chn), .nar(nar),
    .first(first), .last(last), .cmd_clr(cmd_clr)
  );

  wbp_joiner u_join (
    .clk(clk), .rst_n(arst_n),
    .in_fire(in_fire), .in_data(in_data), .busy(busy), .chn(chn), .nar(nar),
    .first(first), .last(last), .cmd_clr(cmd_clr), .sw_clear(sw_clear),
    .join_sent(join_sent), .emit(emit), .emit_word(emit_word), .flag(hold_flag)
  );

  wbp_out_stage u_out (
    .clk(clk), .rst_n(arst_n),
    .emit(emit), .emit_word(emit_word), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_be(out_be),
    .slot_free(slot_free), .join_sent(join_sent)
  );

  // R4
  normal_no_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (in_fire && !chn) |=> !$rose(hold_flag));
endmodule

// File: tb/tb_wide_byte_packer.sv
`timescale 1ns/1ps
module tb_wide_byte_packer;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_chained, cmd_recv, cmd_narrow;
  logic [CNT_W-1:0] cmd_count;
  logic cmd_ready, in_valid, in_ready, out_valid, out_ready, hold_flag, sw_clear;
  logic [7:0]  in_data;
  logic [15:0] out_data;
  logic [1:0]  out_be;

  always #4 clk = ~clk;

  wide_byte_packer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_count(cmd_count),
    .cmd_chained(cmd_chained), .cmd_recv(cmd_recv), .cmd_narrow(cmd_narrow),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_be(out_be), .hold_flag(hold_flag), .sw_clear(sw_clear)
  );

  int checks = 0;
  int errors = 0;
  int rdy_pct = 100;
  bit mon_on = 1'b0;
  bit m_flag = 1'b0;
  logic [7:0] m_held = '0;
  logic [17:0] exp_q[$];
  string       exp_t[$];

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic [1:0] be, input logic [15:0] d);
    return {be, d};
  endfunction

  // output monitor: random backpressure, ordered comparison, stall stability (R10)
  initial begin
    bit stalled = 1'b0;
    logic [17:0] prev = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 100) < rdy_pct;
      #2;
      if (mon_on) begin
        if (stalled) begin
          checks++;
          if (!out_valid || {out_be, out_data} !== prev) begin
            errors++;
            $display("FAIL R10 stalled word changed actual=%0b/%h expected=1/%h",
                     out_valid, {out_be, out_data}, prev);
          end
        end
        stalled = out_valid && !out_ready;
        prev    = {out_be, out_data};
        if (out_valid && out_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected word actual=%h expected=none", {out_be, out_data});
          end else begin
            logic [17:0] e;
            string t;
            e = exp_q.pop_front();
            t = exp_t.pop_front();
            if ({out_be, out_data} !== e) begin
              errors++;
              $display("FAIL %s word actual=%h expected=%h", t, {out_be, out_data}, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic move(input int cnt, input bit chn, input bit recv, input bit nar,
                      input bit clr_before, input bit clr_last, input string ftag);
    logic [7:0] bs[16];
    bit have;
    logic [7:0] lo;
    for (int i = 0; i < 16; i++) bs[i] = 8'($urandom);
    if (cnt != 0) begin
      if (recv) m_flag = 1'b0;
      else if (nar) begin
        m_flag = 1'b0;
        for (int i = 0; i < cnt; i++) begin
          exp_q.push_back(mk(2'b01, {8'h00, bs[i]})); exp_t.push_back("R7");
        end
      end else begin
        if (clr_before) m_flag = 1'b0;
        have = m_flag; lo = m_held; m_flag = 1'b0;
        for (int i = 0; i < cnt; i++) begin
          if (have) begin
            exp_q.push_back(mk(2'b11, {bs[i], lo}));
            exp_t.push_back(i == 0 ? "R5" : "R1");
            have = 1'b0;
          end else if (i == cnt - 1) begin
            if (chn) begin
              if (!clr_last) begin m_flag = 1'b1; m_held = bs[i]; end
            end else begin
              exp_q.push_back(mk(2'b01, {8'h00, bs[i]})); exp_t.push_back("R2");
            end
          end else begin
            lo = bs[i]; have = 1'b1;
          end
        end
      end
    end
    // command
    @(negedge clk); #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    cmd_valid = 1'b1; cmd_count = CNT_W'(cnt); cmd_chained = chn;
    cmd_recv = recv; cmd_narrow = nar;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (clr_before) begin
      sw_clear = 1'b1;
      @(negedge clk);
      sw_clear = 1'b0;
    end
    // bytes
    if (!recv && cnt != 0) begin
      for (int i = 0; i < cnt; i++) begin
        if ($urandom % 4 == 0) begin @(negedge clk); in_valid = 1'b0; end
        @(negedge clk);
        in_valid = 1'b1; in_data = bs[i];
        if (clr_last && i == cnt - 1) sw_clear = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; sw_clear = 1'b0;
    end
    begin
      int w = 0;
      while (exp_q.size() != 0 && w < 2000) begin @(negedge clk); w++; end
    end
    repeat (3) @(negedge clk);
    check_bit({ftag, " hold_flag"}, hold_flag, m_flag);
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_clear = 1'b1;
    @(negedge clk); sw_clear = 1'b0;
    m_flag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_count = '0; cmd_chained = 1'b0;
    cmd_recv = 1'b0; cmd_narrow = 1'b0; in_valid = 1'b0; in_data = '0; sw_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check_bit("R11 out_valid", out_valid, 1'b0);
    check_bit("R11 hold_flag", hold_flag, 1'b0);
    check_bit("R11 cmd_ready", cmd_ready, 1'b1);
    mon_on = 1'b1;

    move(4, 0, 0, 0, 0, 0, "R1");            // even normal
    move(3, 0, 0, 0, 0, 0, "R4");            // odd normal, no hold (R2, R4)
    rdy_pct = 40;
    move(3, 1, 0, 0, 0, 0, "R3");            // chained odd: hold
    move(0, 0, 0, 0, 0, 0, "R9");            // zero count keeps hold
    move(5, 0, 0, 0, 0, 0, "R6");            // join into normal move, then clear
    move(1, 1, 0, 0, 0, 0, "R3");            // hold single byte
    move(2, 1, 0, 0, 0, 0, "R5");            // join then hold again
    move(1, 0, 0, 0, 0, 0, "R6");            // join only word
    move(3, 1, 0, 0, 0, 0, "R3");
    move(3, 0, 1, 0, 0, 0, "R7");            // receive clears
    move(2, 0, 0, 0, 0, 0, "R7");            // no join afterwards
    move(1, 1, 0, 0, 0, 0, "R3");
    move(3, 0, 0, 1, 0, 0, "R7");            // narrow clears, bytes alone
    move(1, 1, 0, 0, 0, 0, "R3");
    sw_pulse();
    check_bit("R8 idle clear hold_flag", hold_flag, 1'b0);
    move(2, 0, 0, 0, 0, 0, "R8");            // kept byte never sent
    move(3, 1, 0, 0, 0, 0, "R3");
    move(4, 1, 0, 0, 1, 0, "R8");            // clear before first byte
    move(3, 1, 0, 0, 0, 1, "R8");            // clear wins over hold
    move(2, 0, 0, 0, 0, 0, "R8");

    rdy_pct = 70;
    for (int k = 0; k < 80; k++) begin
      int r, c;
      bit ch, rc, nr, cb;
      r  = int'($urandom % 10);
      c  = int'($urandom % 8);
      ch = 1'($urandom);
      rc = (r == 0);
      nr = (r == 1);
      cb = (r == 2) && !rc && !nr;
      rdy_pct = 30 + int'($urandom % 71);
      move(c, ch, rc, nr, cb, 0, "R5");
    end

    repeat (5) @(negedge clk);
    check_bit("R9 leftover words", exp_q.size() == 0, 1'b1);
    summary();
    $finish;
  end
endmodule